// File: doc/BRIEF.md
# GPIO Pin Interrupt Slice

This block is the control and status slice for a single general-purpose pin. It holds one 32-bit control word that software writes and reads. The word selects whether the pin drives its pad and at what value. It selects how the pin's input is watched for interrupts: edge or level, which polarity or both edges, and whether events are recorded and forwarded. It also carries two sticky event flags: one for the interrupt path and one for the wake path. The input is assumed to be debounced already. The slice samples it once per clock and compares the new sample with the one before it.

A detected event sets the interrupt status flag only while interrupt enable is set. The mask bit works separately from enable. Masking blocks the request output but does not stop recording, so when a masked pin is unmasked, its pending event is raised. Both flags are cleared by writing them back as one. If an event arrives in the same cycle as the clear, the event wins.

The write port and the read port are plain control and status signals. No data streams through the slice, so it has no valid/ready handshake and never applies back-pressure. A write takes effect on the clock edge where `wr_en` is high. `rd_data` always shows the current word.

Top module: `gpio_irq_slice`

## Requirements
- R1: While reset is active, and right after it, every bit of `rd_data` reads zero, and `irq_req`, `wake_req`, `pad_oe` and `pad_out` are low. The first input sample taken after reset is never treated as an edge.
- R2: The configuration bits read back as written. Bit 0 is the trigger type, bits 2:1 the polarity, bit 3 interrupt enable, bit 4 unmask, bit 5 output value, bit 6 output enable, and bit 10 wake enable. Bits 31:11 read zero. Writing 1 to a status bit (bit 8 or bit 9) never sets it.
- R3: `pad_oe` follows bit 6. `pad_out` follows bit 5 while bit 6 is 1, and is 0 while bit 6 is 0.
- R4: Bit 7 is read-only. It shows the level of `pin_in` as sampled at the most recent rising clock edge.
- R5: In edge mode (bit 0 = 0), polarity 01 detects rising edges, 00 falling edges and 10 both edges. The interrupt status, bit 8, is set at the second rising clock edge after `pin_in` changes.
- R6: In edge mode, the transition that was not selected and a steady input both leave bit 8 clear.
- R7: In level mode (bit 0 = 1), polarity 01 detects high and 00 detects low. Bit 8 is set on every clock while the sampled level is active, and stays set after the level goes away until it is cleared.
- R8: An event is recorded in bit 8 only while bit 3 is 1. A write in the same cycle as the event does not change this: the enable value held before that write is the one used. `irq_req` is high only when bit 8, bit 3 and bit 4 are all 1 (bit 4 = 1 means unmasked). A masked pin still records events.
- R9: Writing 1 to bit 8 clears it. If an event is detected in the same cycle as the clear, bit 8 stays set.
- R10: Polarity 11 never records an event. Level mode with polarity 10 never records an event.
- R11: While bit 10 is 1, the same events set the wake status, bit 9, whatever the value of bit 3. Writing 1 to bit 9 clears it. `wake_req` equals bit 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Writes `wr_data` into the control word on this edge |
| wr_data | input | 32 | Write value; 1 in bits 8 and 9 clears those flags |
| rd_data | output | 32 | Current control word, including live level and flags |
| pin_in | input | 1 | Debounced pin input level |
| pad_oe | output | 1 | Pad output enable |
| pad_out | output | 1 | Pad output value |
| irq_req | output | 1 | Interrupt request of this pin |
| wake_req | output | 1 | Wake request of this pin |

## Verification
The configuration fields, the pad outputs and the cleared flags change on the clock edge where `wr_en` is seen. The live level, bit 7, changes one edge after `pin_in` changes. Status, `irq_req` and `wake_req` change two edges after the input change that causes them. Each table row drives its inputs on a falling clock edge and compares every output at the next falling edge, so one rising edge falls between stimulus and check. The expected values in the table were worked out with this two-stage latency: an event caused by row N first shows in row N+1. The directed tests add the idle cycles that the same latency needs before each check.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned CW_W = 32;

  localparam int unsigned B_TRIG   = 0;
  localparam int unsigned B_POL_LO = 1;
  localparam int unsigned B_POL_HI = 2;
  localparam int unsigned B_EN     = 3;
  localparam int unsigned B_UNMASK = 4;
  localparam int unsigned B_OVAL   = 5;
  localparam int unsigned B_OE     = 6;
  localparam int unsigned B_LIVE   = 7;
  localparam int unsigned B_STS    = 8;
  localparam int unsigned B_WSTS   = 9;
  localparam int unsigned B_WEN    = 10;
  localparam int unsigned USED_BITS = B_WEN + 1;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_BAD  = 2'b11
  } pol_e;

  typedef struct packed {
    logic wake_en;
    logic out_en;
    logic out_val;
    logic unmask;
    logic irq_en;
    pol_e pol;
    logic trig_lvl;
  } cfg_t;

endpackage

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_q,
  output logic pin_prev
);

  logic primed;

  // The first sample after reset loads both stages, so no false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed   <= 1'b0;
      pin_q    <= 1'b0;
      pin_prev <= 1'b0;
    end else begin
      primed   <= 1'b1;
      pin_q    <= pin_in;
      pin_prev <= primed ? pin_q : pin_in;
    end
  end

endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect
  import gpio_irq_pkg::*;
(
  input  logic pin_q,
  input  logic pin_prev,
  input  cfg_t cfg,
  output logic hit
);

  logic rise;
  logic fall;

  always_comb begin
    rise = pin_q & ~pin_prev;
    fall = ~pin_q & pin_prev;
    unique case (cfg.pol)
      POL_LOW:  hit = cfg.trig_lvl ? ~pin_q : fall;
      POL_HIGH: hit = cfg.trig_lvl ?  pin_q : rise;
      POL_BOTH: hit = cfg.trig_lvl ? 1'b0   : (rise | fall);
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/gpio_ctrl_word.sv
module gpio_ctrl_word
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = CW_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         hit,
  output cfg_t         cfg,
  output logic         sts,
  output logic         wsts
);

  cfg_t cfg_wr;
  logic clr_sts;
  logic clr_wsts;
  logic unused_wr;

  always_comb begin
    cfg_wr.trig_lvl = wr_data[B_TRIG];
    cfg_wr.pol      = pol_e'(wr_data[B_POL_HI:B_POL_LO]);
    cfg_wr.irq_en   = wr_data[B_EN];
    cfg_wr.unmask   = wr_data[B_UNMASK];
    cfg_wr.out_val  = wr_data[B_OVAL];
    cfg_wr.out_en   = wr_data[B_OE];
    cfg_wr.wake_en  = wr_data[B_WEN];
    clr_sts         = wr_en & wr_data[B_STS];
    clr_wsts        = wr_en & wr_data[B_WSTS];
  end

  assign unused_wr = ^{wr_data[W-1:USED_BITS], wr_data[B_LIVE]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= '0;
      sts  <= 1'b0;
      wsts <= 1'b0;
    end else begin
      if (wr_en) cfg <= cfg_wr;
      // A new event outranks a same-cycle clear.
      sts  <= (hit & cfg.irq_en)  | (sts  & ~clr_sts);
      wsts <= (hit & cfg.wake_en) | (wsts & ~clr_wsts);
    end
  end

endmodule

// File: rtl/gpio_irq_slice.sv
module gpio_irq_slice
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WORD_W = CW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              pin_in,
  output logic              pad_oe,
  output logic              pad_out,
  output logic              irq_req,
  output logic              wake_req
);

  logic pin_q;
  logic pin_prev;
  logic hit;
  logic sts;
  logic wsts;
  cfg_t cfg;

  gpio_pin_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .pin_q    (pin_q),
    .pin_prev (pin_prev)
  );

  gpio_event_detect u_detect (
    .pin_q    (pin_q),
    .pin_prev (pin_prev),
    .cfg      (cfg),
    .hit      (hit)
  );

  gpio_ctrl_word #(.W(WORD_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .hit     (hit),
    .cfg     (cfg),
    .sts     (sts),
    .wsts    (wsts)
  );

  assign rd_data[USED_BITS-1:0] = {cfg.wake_en, wsts, sts, pin_q, cfg.out_en,
                                   cfg.out_val, cfg.unmask, cfg.irq_en,
                                   cfg.pol, cfg.trig_lvl};

  for (genvar gi = USED_BITS; gi < WORD_W; gi++) begin : g_rsvd
    assign rd_data[gi] = 1'b0;
  end

  assign pad_oe   = cfg.out_en;
  assign pad_out  = cfg.out_en & cfg.out_val;
  assign irq_req  = sts & cfg.irq_en & cfg.unmask;
  assign wake_req = wsts;

endmodule

// File: rtl/gpio_irq_slice_chk.sv
module gpio_irq_slice_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WORD_W = CW_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              pin_in,
  input logic              pad_oe,
  input logic              pad_out,
  input logic              irq_req,
  input logic              wake_req
);

  logic unused_chk;
  assign unused_chk = ^{wr_data[WORD_W-1:B_WSTS+1], wr_data[B_STS-1:0]};

  AST_LIVE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rd_data[B_LIVE] == $past(pin_in)); // R4

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[B_STS] && !(wr_en && wr_data[B_STS]) |=> rd_data[B_STS]); // R9

  AST_CLR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[B_STS] && !rd_data[B_EN] |=> !rd_data[B_STS]); // R9

  AST_NO_REC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_STS] && !rd_data[B_EN] |=> !rd_data[B_STS]); // R8

  AST_REQ_NEEDS_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> rd_data[B_STS] && rd_data[B_UNMASK] && rd_data[B_EN]); // R8

  AST_BAD_POL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_STS] && rd_data[B_POL_HI:B_POL_LO] == 2'b11 |=> !rd_data[B_STS]); // R10

  AST_PAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> !pad_out); // R3

  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req && !(wr_en && wr_data[B_WSTS]) |=> wake_req); // R11

endmodule

bind gpio_irq_slice gpio_irq_slice_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .pin_in   (pin_in),
  .pad_oe   (pad_oe),
  .pad_out  (pad_out),
  .irq_req  (irq_req),
  .wake_req (wake_req)
);

// File: tb/gpio_irq_slice_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_slice_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pin_in;
  logic        pad_oe;
  logic        pad_out;
  logic        irq_req;
  logic        wake_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_slice dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pin_in   (pin_in),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .irq_req  (irq_req),
    .wake_req (wake_req)
  );

  // Row: {wr, wdata[11:0], pin, exp_rd[11:0], exp_req, exp_wake, exp_pad{oe,out}}
  localparam int NV = 31;
  localparam logic [29:0] VT [NV] = '{
    {1'b1, 12'h01A, 1'b0, 12'h01A, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h09A, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h19A, 1'b1, 1'b0, 2'b00},
    {1'b1, 12'h11A, 1'b1, 12'h09A, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h01A, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h01A, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h018, 1'b1, 12'h098, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h018, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h118, 1'b1, 1'b0, 2'b00},
    {1'b1, 12'h008, 1'b0, 12'h108, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h018, 1'b0, 12'h118, 1'b1, 1'b0, 2'b00},
    {1'b1, 12'h11B, 1'b1, 12'h09B, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h19B, 1'b1, 1'b0, 2'b00},
    {1'b1, 12'h11B, 1'b1, 12'h19B, 1'b1, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h11B, 1'b1, 1'b0, 2'b00},
    {1'b1, 12'h11B, 1'b0, 12'h01B, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h013, 1'b1, 12'h093, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h093, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h41C, 1'b1, 12'h49C, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h41C, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b0, 12'h71C, 1'b1, 1'b1, 2'b00},
    {1'b1, 12'h71C, 1'b1, 12'h49C, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h79C, 1'b1, 1'b1, 2'b00},
    {1'b1, 12'h31E, 1'b0, 12'h01E, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h09E, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h09E, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h01D, 1'b1, 12'h09D, 1'b0, 1'b0, 2'b00},
    {1'b0, 12'h000, 1'b1, 12'h09D, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h060, 1'b0, 12'h060, 1'b0, 1'b0, 2'b11},
    {1'b1, 12'h020, 1'b0, 12'h020, 1'b0, 1'b0, 2'b00},
    {1'b1, 12'h040, 1'b0, 12'h040, 1'b0, 1'b0, 2'b10}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 6, 16:                 return "R2 config readback";
      1, 4:                     return "R4 live level";
      2, 8, 22:                 return "R5 edge detect";
      5, 7, 19:                 return "R6 edge ignore";
      12, 14, 15:               return "R7 level mode";
      9, 10, 17, 18:            return "R8 enable/mask";
      3, 11, 13, 23:            return "R9 clear";
      20, 21:                   return "R11 wake";
      24, 25, 26, 27:           return "R10 invalid polarity";
      default:                  return "R3 pad drive";
    endcase
  endfunction

  task automatic cmp(string tag, logic [31:0] erd, logic ereq, logic ewk, logic [1:0] epad);
    n_vec++;
    if (rd_data !== erd || irq_req !== ereq || wake_req !== ewk || {pad_oe, pad_out} !== epad) begin
      n_bad++;
      $display("FAIL %s: rd=%h exp %h, req=%b exp %b, wake=%b exp %b, pad=%b exp %b",
               tag, rd_data, erd, irq_req, ereq, wake_req, ewk, {pad_oe, pad_out}, epad);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual hung, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic        v_wr;
    logic [11:0] v_wd;
    logic        v_pin;
    logic [11:0] v_rd;
    logic        v_req;
    logic        v_wk;
    logic [1:0]  v_pad;

    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    pin_in  = 1'b0;
    repeat (3) @(negedge clk);
    cmp("R1 reset state", 32'h0, 1'b0, 1'b0, 2'b00);
    rst_n = 1'b1;

    // Table walk: drive at a falling edge, compare at the next one.
    for (int i = 0; i < NV; i++) begin
      {v_wr, v_wd, v_pin, v_rd, v_req, v_wk, v_pad} = VT[i];
      wr_en   = v_wr;
      wr_data = {20'h0, v_wd};
      pin_in  = v_pin;
      @(negedge clk);
      cmp(row_tag(i), {20'h0, v_rd}, v_req, v_wk, v_pad);
    end

    // R2: reserved bits read zero, status bits cannot be set by writing.
    wr_en   = 1'b1;
    wr_data = 32'hFFFF_FFFF;
    pin_in  = 1'b0;
    @(negedge clk);
    cmp("R2 all-ones write", 32'h0000_047F, 1'b0, 1'b0, 2'b11);
    wr_en = 1'b0;
    @(negedge clk);
    cmp("R10 level with polarity 11", 32'h0000_047F, 1'b0, 1'b0, 2'b11);

    // R1: reset mid-run with the input high.
    rst_n  = 1'b0;
    pin_in = 1'b1;
    #1;
    cmp("R1 async reset", 32'h0, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    rst_n   = 1'b1;
    wr_en   = 1'b1;
    wr_data = 32'h0000_001A;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R1 no false edge after reset", 32'h0000_009A, 1'b0, 1'b0, 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule